// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block runs a serial successive-approximation converter whose serial clock comes from the host. Each sample period has three steps in a fixed order. The block first raises a conversion-start output and holds it for the conversion time. It then runs one serial frame, in which the result is read in and the next control word (a channel select) is written out on the same clock bursts. Finally it waits in a quiet gap until the settling guard band and the acquisition time have both run out, and only then starts the next period. No serial clock or frame activity ever overlaps a conversion or the guard band.

All timing is set by parameters counted in system clock cycles: conversion time, guard band, acquisition time and the half-period of the serial clock. The acquisition time is counted from the sixth falling serial clock edge of the write frame. The result is presented as a one-cycle strobe. It carries no back-pressure: there is no ready input, so the consumer must take the word in the cycle the strobe is high. The result stays on the data pins until the next frame ends.

Top module: `adc_seq_ctrl`

## Requirements
- R1: During and after reset, `conv_start` is low, `rfs_n` and `tfs_n` are high (inactive), `sclk` is high (idle level) and `res_valid` is low.
- R2: From idle, when `en` is seen high at a clock edge, `conv_start` rises in the next cycle.
- R3: `conv_start` stays high for exactly CONV_CYC cycles. Both frame signals fall in the first cycle after it falls. `sclk`, `rfs_n` and `tfs_n` never change from their idle levels while `conv_start` is high.
- R4: A frame holds `rfs_n` and `tfs_n` low together for exactly 2*FRAME_BITS*SCLK_HALF cycles. It contains FRAME_BITS serial clock periods. Each period is SCLK_HALF cycles high followed by SCLK_HALF cycles low, so falling edge k arrives (2k-1)*SCLK_HALF cycles after the frame starts. `sclk` idles high outside frames.
- R5: On `sdout` the block sends the word {channel, FRAME_BITS-CH_BITS zero bits}, MSB first. Each bit is stable while `sclk` is low. The channel is the value of `ctrl_ch` in the cycle before the frame starts.
- R6: `sdin` is sampled once per falling `sclk` edge, MSB first. `res_data` is the low RES_BITS bits of the FRAME_BITS word received.
- R7: `res_valid` is high for exactly one cycle: the first cycle after the frame signals return high. `res_ch` is the channel that was written in the previous frame, or 0 for the first frame after reset.
- R8: While `en` stays high, the next rise of `conv_start` comes exactly at the later of two points: GUARD_CYC cycles after the frame ends, and ACQ_CYC cycles after the sixth falling `sclk` edge. It never comes sooner than GUARD_CYC cycles after the last frame cycle.
- R9: The rise of `conv_start` never comes less than ACQ_CYC cycles after the sixth falling `sclk` edge of the previous write frame.
- R10: If `en` drops during a period, that period still runs to its end, including its frame and gap. After that, no further `conv_start` rise occurs and all pins stay idle. Raising `en` again starts a new period in the next cycle.
- R11: A change of `ctrl_ch` during a frame does not alter that frame's `sdout` bits. It takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run sample periods while high |
| ctrl_ch | input | CH_BITS | Channel select to write in the next frame |
| conv_start | output | 1 | Conversion start to the converter, rising edge starts |
| sclk | output | 1 | Serial clock to the converter, idles high |
| rfs_n | output | 1 | Receive frame, active low |
| tfs_n | output | 1 | Transmit frame, active low |
| sdin | input | 1 | Serial result data from the converter |
| sdout | output | 1 | Serial control data to the converter |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | RES_BITS | Conversion result |
| res_ch | output | CH_BITS | Channel the result was converted on |

## Verification
A state machine stuck in the conversion or gap state shows at the ports within one period: either `conv_start` stays high past CONV_CYC cycles, or the next rise never comes. A serial clock counter that is off by one gives a frame of the wrong length, a sixth falling edge at the wrong cycle, or a shifted `res_data` word, and each of these shows up at the end of the first frame. A mistake in the channel history only appears one frame later, as a wrong `res_ch`. That is why the scenarios change the channel during a frame and check the following two frames.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_XFER = 2'd2,
    ST_GAP  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/adc_seq_timer.sv
// Loadable down-counter that parks at zero.
module adc_seq_timer #(
  parameter int MAXV = 100,
  localparam int W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/adc_seq_sclk.sv
// Serial clock burst generator: each bit is a high half then a low half.
module adc_seq_sclk #(
  parameter int HALF = 5,
  parameter int BITS = 16,
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int NW = $clog2(BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  output logic          sclk_o,
  output logic          fall_o,
  output logic          rise_o,
  output logic          done_o,
  output logic [NW-1:0] nfall_o
);
  logic [HW-1:0] hc;
  logic          ph;
  logic [NW-1:0] nf;
  logic          half_end;

  assign half_end = run && (hc == '0);
  assign fall_o   = half_end && ph;
  assign rise_o   = half_end && !ph && (nf != NW'(BITS));
  assign done_o   = half_end && !ph && (nf == NW'(BITS));
  assign sclk_o   = run ? ph : 1'b1;
  assign nfall_o  = nf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0;
      ph <= 1'b1;
      nf <= '0;
    end else if (start) begin
      hc <= HW'(HALF - 1);
      ph <= 1'b1;
      nf <= '0;
    end else if (run) begin
      if (hc != '0) begin
        hc <= hc - 1'b1;
      end else if (ph) begin
        ph <= 1'b0;
        nf <= nf + 1'b1;
        hc <= HW'(HALF - 1);
      end else begin
        ph <= 1'b1;
        hc <= HW'(HALF - 1);
      end
    end
  end

  // R4: no falling edge beyond the frame length
  assert_fall_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> (nf < NW'(BITS)));
endmodule

// File: rtl/adc_seq_shift.sv
// Receive and transmit shift registers plus channel history.
module adc_seq_shift #(
  parameter int BITS = 16,
  parameter int RES  = 12,
  parameter int CH   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [CH-1:0]  ch_in,
  input  logic           fall,
  input  logic           rise,
  input  logic           done,
  input  logic           sdin,
  output logic           sdout,
  output logic           res_valid,
  output logic [RES-1:0] res_data,
  output logic [CH-1:0]  res_ch
);
  logic [BITS-1:0] tx_sr;
  logic [BITS-1:0] rx_sr;
  logic [CH-1:0]   cur_ch;
  logic [CH-1:0]   prev_ch;

  assign sdout = tx_sr[BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      cur_ch  <= '0;
      prev_ch <= '0;
    end else begin
      if (load) begin
        tx_sr   <= {ch_in, {(BITS-CH){1'b0}}};
        cur_ch  <= ch_in;
        prev_ch <= cur_ch;
      end else if (rise) begin
        tx_sr <= {tx_sr[BITS-2:0], 1'b0};
      end
      if (fall) rx_sr <= {rx_sr[BITS-2:0], sdin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_ch    <= '0;
    end else begin
      res_valid <= done;
      if (done) begin
        res_data <= rx_sr[RES-1:0];
        res_ch   <= prev_ch;
      end
    end
  end

  // R7: strobe lasts one cycle
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

// File: rtl/adc_seq_ctrl.sv
// Sample-period sequencer: conversion, shared read/write frame, quiet gap.
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYC   = 59,
  parameter int GUARD_CYC  = 50,
  parameter int ACQ_CYC    = 200,
  parameter int SCLK_HALF  = 5,
  parameter int FRAME_BITS = 16,  // must be at least 6
  parameter int RES_BITS   = 12,
  parameter int CH_BITS    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [CH_BITS-1:0]  ctrl_ch,
  output logic                conv_start,
  output logic                sclk,
  output logic                rfs_n,
  output logic                tfs_n,
  input  logic                sdin,
  output logic                sdout,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_data,
  output logic [CH_BITS-1:0]  res_ch
);
  localparam int CNV_W = $clog2(CONV_CYC + 1);
  localparam int GRD_W = $clog2(GUARD_CYC + 1);
  localparam int ACQ_W = $clog2(ACQ_CYC + 1);
  localparam int NW    = $clog2(FRAME_BITS + 1);
  localparam int ACQ_EDGE = 6;

  seq_state_t state, nxt;
  logic conv_zero, guard_zero, acq_zero, quiet;
  logic enter_conv, enter_xfer, fall6;
  logic s_fall, s_rise, s_done;
  logic [NW-1:0] nfall;

  assign quiet      = guard_zero && acq_zero;
  assign enter_xfer = (state == ST_CONV) && conv_zero;
  assign enter_conv = (state != ST_CONV) && (nxt == ST_CONV);
  assign fall6      = s_fall && (nfall == NW'(ACQ_EDGE - 1));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (en && quiet) nxt = ST_CONV;
      ST_CONV: if (conv_zero)   nxt = ST_XFER;
      ST_XFER: if (s_done)      nxt = ST_GAP;
      ST_GAP:  if (quiet)       nxt = en ? ST_CONV : ST_IDLE;
      default:                  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign conv_start = (state == ST_CONV);
  assign rfs_n      = (state != ST_XFER);
  assign tfs_n      = (state != ST_XFER);

  adc_seq_timer #(.MAXV(CONV_CYC)) u_conv_tmr (
    .clk(clk), .rst_n(rst_n), .load(enter_conv),
    .val(CNV_W'(CONV_CYC - 1)), .zero(conv_zero));

  adc_seq_timer #(.MAXV(GUARD_CYC)) u_guard_tmr (
    .clk(clk), .rst_n(rst_n), .load(s_done),
    .val(GRD_W'(GUARD_CYC - 1)), .zero(guard_zero));

  adc_seq_timer #(.MAXV(ACQ_CYC)) u_acq_tmr (
    .clk(clk), .rst_n(rst_n), .load(fall6),
    .val(ACQ_W'(ACQ_CYC - 1)), .zero(acq_zero));

  adc_seq_sclk #(.HALF(SCLK_HALF), .BITS(FRAME_BITS)) u_sclk (
    .clk(clk), .rst_n(rst_n), .start(enter_xfer),
    .run(state == ST_XFER), .sclk_o(sclk), .fall_o(s_fall),
    .rise_o(s_rise), .done_o(s_done), .nfall_o(nfall));

  adc_seq_shift #(.BITS(FRAME_BITS), .RES(RES_BITS), .CH(CH_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(enter_xfer), .ch_in(ctrl_ch),
    .fall(s_fall), .rise(s_rise), .done(s_done), .sdin(sdin),
    .sdout(sdout), .res_valid(res_valid), .res_data(res_data),
    .res_ch(res_ch));

  // Port-level window counters used only by the assertions below
  localparam int MAXW = (GUARD_CYC > ACQ_CYC) ? GUARD_CYC : ACQ_CYC;
  localparam int MW   = $clog2(MAXW + 2);
  localparam int HIW  = $clog2(CONV_CYC + 2);
  logic [HIW-1:0] hi_cnt;
  logic [MW-1:0]  end_cnt, six_cnt;
  logic [2:0]     f_cnt;
  logic           sclk_d, framed, seen6, sfell;

  assign sfell = sclk_d && !sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0; end_cnt <= '0; six_cnt <= '0; f_cnt <= '0;
      sclk_d <= 1'b1; framed <= 1'b0; seen6 <= 1'b0;
    end else begin
      sclk_d <= sclk;
      hi_cnt <= conv_start ? hi_cnt + 1'b1 : '0;
      if (!rfs_n) begin
        end_cnt <= '0;
        framed  <= 1'b1;
      end else if (end_cnt != MW'(MAXW + 1)) begin
        end_cnt <= end_cnt + 1'b1;
      end
      if (conv_start)                           f_cnt <= '0;
      else if (sfell && !tfs_n && f_cnt != 3'd7) f_cnt <= f_cnt + 1'b1;
      if (sfell && !tfs_n && f_cnt == 3'(ACQ_EDGE - 1)) begin
        six_cnt <= MW'(1);
        seen6   <= 1'b1;
      end else if (six_cnt != MW'(MAXW + 1)) begin
        six_cnt <= six_cnt + 1'b1;
      end
    end
  end

  assert_no_serial_in_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (rfs_n && tfs_n && sclk));

  assert_conv_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rfs_n && $past(rfs_n)) |-> (hi_cnt == HIW'(CONV_CYC)));

  assert_guard_band_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(conv_start) && framed) |-> (end_cnt >= MW'(GUARD_CYC)));

  assert_acq_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(conv_start) && seen6) |-> (six_cnt >= MW'(ACQ_CYC)));

  assert_valid_after_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (rfs_n && !$past(rfs_n)));
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CONV  = 59;
  localparam int GUARD = 50;
  localparam int ACQ   = 200;
  localparam int HALF  = 5;
  localparam int FB    = 16;
  localparam int RB    = 12;
  localparam int CB    = 3;
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, sdin = 1'b0;
  logic [CB-1:0] ctrl_ch = '0;
  logic conv_start, sclk, rfs_n, tfs_n, sdout, res_valid;
  logic [RB-1:0] res_data;
  logic [CB-1:0] res_ch;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(.CONV_CYC(CONV), .GUARD_CYC(GUARD), .ACQ_CYC(ACQ),
    .SCLK_HALF(HALF), .FRAME_BITS(FB), .RES_BITS(RB), .CH_BITS(CB)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ctrl_ch(ctrl_ch),
    .conv_start(conv_start), .sclk(sclk), .rfs_n(rfs_n), .tfs_n(tfs_n),
    .sdin(sdin), .sdout(sdout), .res_valid(res_valid),
    .res_data(res_data), .res_ch(res_ch));

  int n_checks = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] pat(input int n);
    return 16'hB4E7 + 16'(n * 16'h3A29);
  endfunction

  // Port monitor and converter model, all at the falling clock edge
  int cyc = 0, rise_t = 0, conv_len = 0, frame_t = 0, end_t = 0;
  int frame_len = 0, t6 = 0, nfall = 0, n_rise = 0, n_lo = 0, n_frames = 0;
  int n_valid = 0, val_t = 0, vlen = 0, vlen_max = 0, viol = 0, tmis = 0;
  logic [FB-1:0] tx_cap = '0;
  logic [RB-1:0] val_data = '0;
  logic [CB-1:0] val_ch = '0;
  logic p_conv = 1'b0, p_rfs = 1'b1, p_sclk = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (conv_start && !p_conv) begin rise_t = cyc; n_rise++; end
      if (!conv_start && p_conv) conv_len = cyc - rise_t;
      if (conv_start && (!rfs_n || !tfs_n || !sclk)) viol++;
      if (rfs_n != tfs_n) tmis++;
      if (!rfs_n && p_rfs) begin frame_t = cyc; nfall = 0; tx_cap = '0; n_lo++; end
      if (rfs_n && !p_rfs) begin end_t = cyc; frame_len = cyc - frame_t; n_frames++; end
      if (!sclk && p_sclk) begin
        nfall++;
        if (nfall == 6) t6 = cyc;
        tx_cap = {tx_cap[FB-2:0], sdout};
      end
      if (res_valid) begin
        if (vlen == 0) begin
          n_valid++; val_t = cyc; val_data = res_data; val_ch = res_ch;
        end
        vlen++;
        if (vlen > vlen_max) vlen_max = vlen;
      end else vlen = 0;
      if (!rfs_n && sclk && nfall < FB) begin
        logic [FB-1:0] w;
        w = pat(n_frames);
        sdin = w[FB-1-nfall];
      end else sdin = 1'b0;
    end
    p_conv = conv_start; p_rfs = rfs_n; p_sclk = sclk;
  end

  function automatic int later(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check_frame(input int k, input int ch_tx, input int ch_res);
    chk("R3", "conv_start high cycles", conv_len, CONV);
    chk("R3", "frame start after rise", frame_t - rise_t, CONV);
    chk("R3", "serial activity during conversion", viol, 0);
    chk("R4", "frame length", frame_len, 2*FB*HALF);
    chk("R4", "sixth falling edge offset", t6 - frame_t, 11*HALF);
    chk("R4", "falling edges per frame", nfall, FB);
    chk("R4", "frame signals mismatch", tmis, 0);
    chk("R5", "write word", tx_cap, longint'(ch_tx) << (FB-CB));
    chk("R6", "result data", val_data, pat(k) & 16'h0FFF);
    chk("R7", "valid cycle", val_t, end_t);
    chk("R7", "valid width", vlen_max, 1);
    chk("R7", "result channel", val_ch, ch_res);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "conv_start in reset", conv_start, 0);
    chk("R1", "sclk in reset", sclk, 1);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "conv_start after reset", conv_start, 0);
    chk("R1", "rfs_n after reset", rfs_n, 1);
    chk("R1", "tfs_n after reset", tfs_n, 1);
    chk("R1", "sclk after reset", sclk, 1);
    chk("R1", "res_valid after reset", res_valid, 0);
  endtask

  task automatic t_first_period();
    int en_t;
    @(negedge clk); #1;
    ctrl_ch = 3'd5; en = 1'b1; en_t = cyc;
    wait (n_rise == 1);
    chk("R2", "start after enable", rise_t, en_t + 1);
    wait (n_valid == 1);
    @(negedge clk);
    check_frame(0, 5, 0);
  endtask

  task automatic t_midframe_change();
    int exp_rise;
    exp_rise = later(t6 + ACQ, end_t + GUARD);
    wait (n_rise == 2);
    chk("R8", "second start cycle", rise_t, exp_rise);
    chk("R9", "acq window", (rise_t - t6 >= ACQ) ? 1 : 0, 1);
    wait (n_lo == 2);
    repeat (20) @(negedge clk);
    #1 ctrl_ch = 3'd2;
    wait (n_valid == 2);
    @(negedge clk);
    check_frame(1, 5, 5);  // R11: mid-frame change not yet sent
  endtask

  task automatic t_change_applied();
    int exp_rise;
    exp_rise = later(t6 + ACQ, end_t + GUARD);
    wait (n_rise == 3);
    chk("R8", "third start cycle", rise_t, exp_rise);
    chk("R8", "guard band", (rise_t - end_t >= GUARD) ? 1 : 0, 1);
    wait (n_valid == 3);
    @(negedge clk);
    check_frame(2, 2, 5);  // R11: new channel sent in the next frame
  endtask

  task automatic t_stop_restart();
    int en_t;
    wait (n_rise == 4);
    @(negedge clk); #1 en = 1'b0;
    wait (n_valid == 4);
    @(negedge clk);
    chk("R10", "period finished result channel", val_ch, 2);
    chk("R10", "period finished data", val_data, pat(3) & 16'h0FFF);
    repeat (600) @(negedge clk);
    chk("R10", "no start after disable", n_rise, 4);
    chk("R10", "conv_start idle", conv_start, 0);
    chk("R10", "frames idle", {rfs_n, tfs_n}, 3);
    chk("R10", "sclk idle", sclk, 1);
    #1; en = 1'b1; en_t = cyc;
    wait (n_rise == 5);
    chk("R10", "restart start cycle", rise_t, en_t + 1);
    wait (n_valid == 5);
    @(negedge clk);
    check_frame(4, 2, 2);
  endtask

  initial begin
    t_reset();
    t_first_period();
    t_midframe_change();
    t_change_applied();
    t_stop_restart();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule